// File: doc/BRIEF.md
# Byte-Exchange SPI Master with Prescaled Serial Clock

This block is a register-programmed SPI master that exchanges one byte per transfer with a selected slave. A simple word-addressed host bus reaches seven registers: control, configuration, timing, interrupt cause, interrupt mask, transmit data and receive data. Software selects a slave and drives its select line from the control register. It sets the serial clock rate, polarity, phase and per-direction bit order in the configuration register. It then writes a byte to the transmit register, which starts the exchange.

The serial clock period, in core clock cycles, is a 4-bit rate multiplied by two raised to a 3-bit pre-selection. The pre-selection bits are split across the configuration word. The point at which the input line is sampled can be delayed by one core cycle, which helps when round-trip delay is large at the fastest rates. When all eight bits are done, a ready bit is set in the cause register and the received byte is held for reading. An interrupt output follows the ready bit gated by its mask.

Top module: `spi_prescaled_master`

## Requirements
- R1: After reset, control, configuration, cause, mask and receive data read as 0, and timing reads as 1. The serial clock is low, every select output is high and the interrupt is low.
- R2: Control bit 0 set drives low the select output chosen by the index in control bits 5:4. All other select outputs stay high. With bit 0 clear, all select outputs are high.
- R3: Each bit slot lasts D = max(2, S × 2^P) core cycles. S is configuration bits 3:0, with 0 treated as 1. P is {configuration bits 7:6, configuration bit 4}, with bit 4 as the least significant bit. A transfer keeps control bit 2 (busy) high for exactly 8 × D cycles.
- R4: A write to the transmit register (address 5) with control bit 1 (enable) set and no transfer in progress starts an exchange of exactly 8 bits. The transfer-length field (configuration bits 13:12) is stored and read back but has no effect. The clock shows 8 leading edges.
- R5: Configuration bit 10 set shifts the output LSB first; otherwise MSB first. Configuration bit 11 independently sets the input order in the same way.
- R6: Configuration bit 8 gives the idle clock level. With configuration bit 9 clear, the clock sits at idle for the first floor(D/2) cycles of each slot and is active for the rest. With bit 9 set, the order is reversed. The output bit changes only at slot boundaries.
- R7: The input line is sampled in the slot cycle floor(D/2). When timing bits 1:0 equal 2, it is sampled one cycle later, but never past the last cycle of the slot.
- R8: At the end of the eighth slot, busy falls and cause bit 0 is set. The receive register (address 6) then holds the received byte.
- R9: Writing the cause register with bit 0 = 0 clears the ready bit. Writing it with bit 0 = 1 leaves the bit unchanged.
- R10: The interrupt output is high exactly when cause bit 0 and mask bit 0 are both set.
- R11: A transmit write while busy, or while enable is clear, is ignored. It does not restart, extend or start a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data of the addressed register |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | NUM_CS | Active-low select lines |
| irq | output | 1 | Ready interrupt |

## Verification
The assertions check four things on every cycle: the slot counter restarts after each slot end, busy only rises from an accepted start, a transfer ends only after the eighth slot, and no start is accepted while busy. They also check that completion sets the ready bit, that a clearing write drops it, and that at most one select line is low. Exact clock waveforms, bit order, the sample point and the received byte across rates, modes and delayed sampling can only be shown by the bench's scenarios. The same holds for ignored writes, where the bench compares the ports against its behavioural model every cycle.

// File: rtl/spi_pm_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the prescaled SPI master: register addresses,
// control bit positions, configuration layout and the slot-length rule.
package spi_pm_pkg;
    localparam int SPR_W  = 4;
    localparam int SPPR_W = 3;
    localparam int DIV_W  = SPR_W + (1 << SPPR_W) - 1;
    localparam int BITS   = 8;
    localparam int BIT_W  = $clog2(BITS);

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_CFG   = 3'd1,
        A_TIM   = 3'd2,
        A_CAUSE = 3'd3,
        A_MASK  = 3'd4,
        A_TXD   = 3'd5,
        A_RXD   = 3'd6
    } reg_addr_e;

    localparam int CTRL_SEL  = 0;
    localparam int CTRL_EN   = 1;
    localparam int CTRL_BUSY = 2;
    localparam int CTRL_IDX  = 4;

    localparam logic [1:0] TIM_NORMAL = 2'd1;
    localparam logic [1:0] TIM_LATE   = 2'd2;

    typedef struct packed {
        logic [1:0]        xlen;
        logic              rx_lsb;
        logic              tx_lsb;
        logic              cpha;
        logic              cpol;
        logic [1:0]        sppr_hi;
        logic              rsvd;
        logic              sppr_lo;
        logic [SPR_W-1:0]  spr;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    // Slot length in core cycles: rate times two to the pre-selection, at least 2.
    function automatic logic [DIV_W-1:0] slot_len(input cfg_t c);
        logic [SPR_W-1:0]  rate;
        logic [SPPR_W-1:0] pre;
        logic [DIV_W-1:0]  d;
        rate = (c.spr == '0) ? SPR_W'(1) : c.spr;
        pre  = {c.sppr_hi, c.sppr_lo};
        d    = DIV_W'(rate) << pre;
        if (d < DIV_W'(2)) d = DIV_W'(2);
        return d;
    endfunction
endpackage

// File: rtl/spi_pm_regs.sv
`timescale 1ns/1ps
// Register file of the SPI master: holds control, configuration, timing,
// cause and mask, decodes transfer starts and select lines, muxes reads.
// Assumes single-cycle writes; reads are combinational from the address.
module spi_pm_regs
    import spi_pm_pkg::*;
#(
    parameter int NUM_CS   = 4,
    parameter int BUS_W    = 32,
    parameter int CS_IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [BITS-1:0]   rx_byte,
    output cfg_t              cfg,
    output logic              sample_late,
    output logic              start,
    output logic [BITS-1:0]   tx_byte,
    output logic [NUM_CS-1:0] cs_n,
    output logic              irq
);
    logic                sel_q;
    logic                en_q;
    logic [CS_IDX_W-1:0] idx_q;
    cfg_t                cfg_q;
    logic [1:0]          tim_q;
    logic                cause_q;
    logic                mask_q;
    logic                wr_ctrl, wr_cfg, wr_tim, wr_cause, wr_mask, wr_txd;
    logic                unused_hi;

    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_cfg   = bus_wr && (bus_addr == A_CFG);
    assign wr_tim   = bus_wr && (bus_addr == A_TIM);
    assign wr_cause = bus_wr && (bus_addr == A_CAUSE);
    assign wr_mask  = bus_wr && (bus_addr == A_MASK);
    assign wr_txd   = bus_wr && (bus_addr == A_TXD);
    assign unused_hi = &{1'b0, bus_wdata[BUS_W-1:CFG_W]};

    // Control fields: select enable, transfer enable, select index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            en_q  <= 1'b0;
            idx_q <= '0;
        end else if (wr_ctrl) begin
            sel_q <= bus_wdata[CTRL_SEL];
            en_q  <= bus_wdata[CTRL_EN];
            idx_q <= bus_wdata[CTRL_IDX +: CS_IDX_W];
        end
    end

    // Configuration, timing and mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            tim_q  <= TIM_NORMAL;
            mask_q <= 1'b0;
        end else begin
            if (wr_cfg)  cfg_q  <= cfg_t'(bus_wdata[CFG_W-1:0]);
            if (wr_tim)  tim_q  <= bus_wdata[1:0];
            if (wr_mask) mask_q <= bus_wdata[0];
        end
    end

    // Ready cause: set on completion, cleared by writing a zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cause_q <= 1'b0;
        else if (done)                       cause_q <= 1'b1;
        else if (wr_cause && !bus_wdata[0])  cause_q <= 1'b0;
    end

    assign cfg         = cfg_q;
    assign sample_late = (tim_q == TIM_LATE);
    assign start       = wr_txd && en_q && !busy;
    assign tx_byte     = bus_wdata[BITS-1:0];
    assign irq         = cause_q & mask_q;

    // One select decoder per output line.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
        assign cs_n[g] = !(sel_q && (idx_q == CS_IDX_W'(g)));
    end

    // Read mux by address.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[CTRL_SEL]  = sel_q;
                bus_rdata[CTRL_EN]   = en_q;
                bus_rdata[CTRL_BUSY] = busy;
                bus_rdata[CTRL_IDX +: CS_IDX_W] = idx_q;
            end
            A_CFG:   bus_rdata[CFG_W-1:0] = cfg_q;
            A_TIM:   bus_rdata[1:0]       = tim_q;
            A_CAUSE: bus_rdata[0]         = cause_q;
            A_MASK:  bus_rdata[0]         = mask_q;
            A_RXD:   bus_rdata[BITS-1:0]  = rx_byte;
            default: bus_rdata = '0;
        endcase
    end

    a_r8_done_sets_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cause_q);
    a_r9_cause_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cause && !bus_wdata[0] && !done) |=> !cause_q);
    a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
endmodule

// File: rtl/spi_pm_clkgen.sv
`timescale 1ns/1ps
// Slot timer: counts core cycles within each bit slot, drives the serial
// clock level and issues the sample and slot-end strobes.
// Assumes configuration is not changed while a transfer is in progress.
module spi_pm_clkgen
    import spi_pm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  cfg_t cfg,
    input  logic sample_late,
    output logic slot_end,
    output logic sample_now,
    output logic sck
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] spt;
    logic             first_half;
    logic             active;
    logic             unused_cfg;

    assign unused_cfg = &{1'b0, cfg.xlen, cfg.rx_lsb, cfg.tx_lsb, cfg.rsvd};
    assign div  = slot_len(cfg);
    assign half = div >> 1;
    assign spt  = (sample_late && ((half + DIV_W'(1)) < div)) ? half + DIV_W'(1) : half;

    assign slot_end   = busy && (cnt_q >= div - DIV_W'(1));
    assign sample_now = busy && (cnt_q == spt);
    assign first_half = cnt_q < half;
    assign active     = busy && (first_half == cfg.cpha);
    assign sck        = cfg.cpol ^ active;

    // Cycle counter within the current slot; parked at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy || slot_end) cnt_q <= '0;
        else                             cnt_q <= cnt_q + DIV_W'(1);
    end

    a_r3_wrap_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> (cnt_q == '0));
endmodule

// File: rtl/spi_pm_shifter.sv
`timescale 1ns/1ps
// Byte shifter: tracks the busy window and bit count, shifts the transmit
// byte at slot ends and assembles the received byte at sample strobes.
module spi_pm_shifter
    import spi_pm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BITS-1:0] tx_byte,
    input  logic            slot_end,
    input  logic            sample_now,
    input  logic            miso,
    input  logic            tx_lsb,
    input  logic            rx_lsb,
    output logic            busy,
    output logic            done,
    output logic            mosi,
    output logic [BITS-1:0] rx_byte
);
    logic             busy_q;
    logic [BIT_W-1:0] bit_q;
    logic [BITS-1:0]  tx_q;
    logic [BITS-1:0]  rx_q;

    assign done    = busy_q && slot_end && (bit_q == BIT_W'(BITS - 1));
    assign busy    = busy_q;
    assign mosi    = busy_q & (tx_lsb ? tx_q[0] : tx_q[BITS-1]);
    assign rx_byte = rx_q;

    // Busy window and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            bit_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            bit_q  <= '0;
        end else if (busy_q && slot_end) begin
            bit_q  <= bit_q + BIT_W'(1);
            if (done) busy_q <= 1'b0;
        end
    end

    // Transmit shift register: load on start, advance at each slot end.
    always_ff @(posedge clk) begin
        if (!rst_n)                 tx_q <= '0;
        else if (start)             tx_q <= tx_byte;
        else if (busy_q && slot_end) tx_q <= tx_lsb ? (tx_q >> 1) : (tx_q << 1);
    end

    // Receive shift register: one input bit per sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rx_q <= '0;
        else if (busy_q && sample_now) rx_q <= rx_lsb ? {miso, rx_q[BITS-1:1]}
                                                      : {rx_q[BITS-2:0], miso};
    end

    a_r4_rise_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(start));
    a_r4_eight_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(bit_q) == BIT_W'(BITS - 1)));
    a_r11_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !start);
endmodule

// File: rtl/spi_prescaled_master.sv
`timescale 1ns/1ps
// Top of the byte-exchange SPI master. Connects the register file, slot
// timer and shifter. Assumes a synchronous active-low reset and that the
// slave input is already synchronous to the core clock.
module spi_prescaled_master
    import spi_pm_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n,
    output logic              irq
);
    localparam int CS_IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    cfg_t            cfg;
    logic            sample_late;
    logic            start;
    logic [BITS-1:0] tx_byte;
    logic [BITS-1:0] rx_byte;
    logic            busy;
    logic            done;
    logic            slot_end;
    logic            sample_now;

    spi_pm_regs #(
        .NUM_CS   (NUM_CS),
        .BUS_W    (BUS_W),
        .CS_IDX_W (CS_IDX_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .busy        (busy),
        .done        (done),
        .rx_byte     (rx_byte),
        .cfg         (cfg),
        .sample_late (sample_late),
        .start       (start),
        .tx_byte     (tx_byte),
        .cs_n        (spi_cs_n),
        .irq         (irq)
    );

    spi_pm_clkgen u_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy),
        .cfg         (cfg),
        .sample_late (sample_late),
        .slot_end    (slot_end),
        .sample_now  (sample_now),
        .sck         (spi_sck)
    );

    spi_pm_shifter u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .tx_byte    (tx_byte),
        .slot_end   (slot_end),
        .sample_now (sample_now),
        .miso       (spi_miso),
        .tx_lsb     (cfg.tx_lsb),
        .rx_lsb     (cfg.rx_lsb),
        .busy       (busy),
        .done       (done),
        .mosi       (spi_mosi),
        .rx_byte    (rx_byte)
    );
endmodule

// File: tb/test_spi_prescaled_master.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural reference model advanced on every
// rising edge and compared with the ports every cycle, plus scenario checks.
module test_spi_prescaled_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [3:0]  spi_cs_n;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit cmp_en   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    spi_prescaled_master i_spi_prescaled_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq(irq)
    );

    // Slave input: pseudo-random bit changed every falling edge.
    logic [15:0] lfsr = 16'hACE1;
    assign spi_miso = lfsr[0];
    always @(negedge clk) lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};

    // Reference model state.
    bit        m_sel, m_en, m_busy, m_cause, m_mask, m_done;
    int        m_idx, m_c, m_bit;
    logic [13:0] m_cfg;
    logic [1:0]  m_tim;
    logic [7:0]  m_tx, m_rx;
    bit        m_b0;

    function automatic int div_of(input logic [13:0] c);
        int s, p, d;
        s = (c[3:0] == 4'd0) ? 1 : int'(c[3:0]);
        p = int'({c[7:6], c[4]});
        d = s << p;
        return (d < 2) ? 2 : d;
    endfunction

    function automatic int samp_of(input logic [13:0] c, input logic [1:0] t);
        int dv, h;
        dv = div_of(c);
        h  = dv / 2;
        return (t == 2'd2 && h + 1 < dv) ? h + 1 : h;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_en = 0; m_idx = 0; m_cfg = '0; m_tim = 2'd1;
            m_cause = 0; m_mask = 0; m_busy = 0; m_c = 0; m_bit = 0;
            m_tx = '0; m_rx = '0;
        end else begin
            m_b0 = m_busy;
            m_done = 0;
            if (m_busy) begin
                if (m_c == samp_of(m_cfg, m_tim))
                    m_rx = m_cfg[11] ? {spi_miso, m_rx[7:1]} : {m_rx[6:0], spi_miso};
                if (m_c >= div_of(m_cfg) - 1) begin
                    m_c = 0;
                    m_tx = m_cfg[10] ? (m_tx >> 1) : (m_tx << 1);
                    if (m_bit == 7) begin m_busy = 0; m_done = 1; m_bit = 0; end
                    else m_bit++;
                end else m_c++;
            end
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: begin m_sel = bus_wdata[0]; m_en = bus_wdata[1]; m_idx = int'(bus_wdata[5:4]); end
                    3'd1: m_cfg = bus_wdata[13:0];
                    3'd2: m_tim = bus_wdata[1:0];
                    3'd4: m_mask = bus_wdata[0];
                    3'd5: if (m_en && !m_b0) begin
                              m_busy = 1; m_c = 0; m_bit = 0; m_tx = bus_wdata[7:0];
                          end
                    default: ;
                endcase
            end
            if (m_done) m_cause = 1;
            else if (bus_wr && bus_addr == 3'd3 && !bus_wdata[0]) m_cause = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison of the ports with the model, mid high phase.
    always @(posedge clk) begin
        #5;
        if (cmp_en && !finished) begin
            logic [31:0] er;
            logic [3:0]  ecs;
            logic        esck;
            int          h;
            h = div_of(m_cfg) / 2;
            esck = m_cfg[8] ^ (m_busy && ((m_c < h) == m_cfg[9]));
            ecs = 4'hF;
            if (m_sel) ecs[m_idx] = 1'b0;
            er = '0;
            case (bus_addr)
                3'd0: er = {26'd0, 2'(m_idx), 1'b0, m_busy, m_en, m_sel};
                3'd1: er = {18'd0, m_cfg};
                3'd2: er = {30'd0, m_tim};
                3'd3: er = {31'd0, m_cause};
                3'd4: er = {31'd0, m_mask};
                3'd6: er = {24'd0, m_rx};
                default: er = '0;
            endcase
            chk("R3 R6 serial clock", {31'd0, spi_sck}, {31'd0, esck});
            chk("R5 serial out", {31'd0, spi_mosi}, {31'd0, m_busy && (m_cfg[10] ? m_tx[0] : m_tx[7])});
            chk("R2 selects", {28'd0, spi_cs_n}, {28'd0, ecs});
            chk("R10 interrupt", {31'd0, irq}, {31'd0, m_cause & m_mask});
            chk("R8 R7 read data", bus_rdata, er);
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk); bus_addr = a[2:0];
        @(posedge clk); #5; v = bus_rdata;
    endtask

    // Run one byte exchange; measure busy cycles and leading clock edges.
    task automatic xfer(input logic [7:0] d, input int dv, input int poke);
        int nb, edges;
        logic cp, prev;
        cp = m_cfg[8];
        @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = {24'd0, d};
        @(posedge clk); #5;
        nb = 1; edges = 0;
        if (spi_sck !== cp) edges++;
        prev = spi_sck;
        @(negedge clk); bus_wr = 1'b0; bus_addr = 3'd0;
        for (int k = 0; k < 20000; k++) begin
            @(posedge clk); #5;
            if (prev == cp && spi_sck != cp) edges++;
            prev = spi_sck;
            if (bus_rdata[2] == 1'b0) break;
            nb++;
            if (nb == poke) begin
                @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = {24'd0, ~d};
                @(posedge clk); #5;
                if (prev == cp && spi_sck != cp) edges++;
                prev = spi_sck;
                nb++;
                @(negedge clk); bus_wr = 1'b0; bus_addr = 3'd0;
            end
        end
        if (poke > 0) chk("R11 busy write ignored, busy cycles", nb, 8 * dv);
        else          chk("R3 busy cycles", nb, 8 * dv);
        chk("R4 leading edges", edges, 8);
    endtask

    task automatic summary;
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1;
        // R1 reset state
        rd(0, v); chk("R1 control", v, 32'h0);
        rd(1, v); chk("R1 config", v, 32'h0);
        rd(2, v); chk("R1 timing", v, 32'h1);
        rd(3, v); chk("R1 cause", v, 32'h0);
        rd(4, v); chk("R1 mask", v, 32'h0);
        rd(6, v); chk("R1 receive", v, 32'h0);
        chk("R1 clock", {31'd0, spi_sck}, 32'h0);
        chk("R1 selects", {28'd0, spi_cs_n}, 32'hF);
        chk("R1 interrupt", {31'd0, irq}, 32'h0);
        // R2 select decode
        wr(0, 32'h23); rd(0, v);
        chk("R2 select index 2", {28'd0, spi_cs_n}, 32'hB);
        wr(0, 32'h22); rd(0, v);
        chk("R2 select off", {28'd0, spi_cs_n}, 32'hF);
        wr(0, 32'h23);
        // Mode 0, fastest slot
        xfer(8'hA5, 2, 0);
        rd(3, v); chk("R8 ready set", v, 32'h1);
        rd(6, v); chk("R8 received byte", v, {24'd0, m_rx});
        // R6 R7 mode 3, odd-free divisor 6, late sample
        wr(1, 32'h313); wr(2, 32'h2);
        xfer(8'h3C, 6, 0);
        rd(6, v); chk("R7 late sample byte", v, {24'd0, m_rx});
        // R3 R5 large divisor, output LSB first
        wr(1, 32'h495); wr(2, 32'h1);
        xfer(8'h96, 160, 0);
        rd(6, v); chk("R5 received byte", v, {24'd0, m_rx});
        // R4 length field ignored, rate 0 as 1, input LSB first
        wr(1, 32'h3940);
        rd(1, v); chk("R4 length field stored", v, 32'h3940);
        xfer(8'h5A, 4, 0);
        rd(6, v); chk("R5 input LSB first", v, {24'd0, m_rx});
        // R11 write while busy, odd divisor, late sample, phase 1
        wr(1, 32'h207); wr(2, 32'h2);
        xfer(8'hC3, 7, 5);
        // R9 R10 cause and interrupt
        wr(3, 32'h1); rd(3, v); chk("R9 write one keeps", v, 32'h1);
        wr(4, 32'h1); rd(4, v); chk("R10 irq with mask", {31'd0, irq}, 32'h1);
        wr(3, 32'h0); rd(3, v); chk("R9 write zero clears", v, 32'h0);
        chk("R10 irq after clear", {31'd0, irq}, 32'h0);
        // R11 write with enable clear
        wr(0, 32'h21); wr(5, 32'hFF);
        rd(0, v); chk("R11 no start when disabled", {31'd0, v[2]}, 32'h0);
        repeat (10) @(negedge clk);
        rd(3, v); chk("R11 no completion when disabled", v, 32'h0);
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule